// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of an 8-bit successive-approximation converter that sits on a microprocessor-style bus. An analog comparator is outside the block and feeds one compare bit back into it. On each conversion the block presents a trial code on `trial_o`. It reads the compare bit and decides the result one bit at a time, starting with the most significant bit. It then moves the finished word into an output latch and pulls an active-low interrupt low. A bus read drives the latched word onto the data outputs, raises the output-enable flag in place of a tri-state driver, and clears the interrupt.

The active-low chip select, write and read strobes each pass through a two-flop synchronizer. While select and write are both low, the converter stays in a reset hold. The conversion starts only after the strobe is released, on the next boundary of a free-running 8-clock phase counter. A new start during a conversion abandons that conversion and leaves the latch unchanged. The interrupt output can be looped back to the write strobe, with select tied low, to get continuous conversions after one forced start pulse. The FSM states are IDLE, HOLD, ALIGN, CONV and XFER. The transitions are:
- IDLE→HOLD when a start is seen.
- HOLD→ALIGN on release.
- ALIGN→CONV at the phase boundary.
- CONV→CONV from bit to bit.
- CONV→XFER after the last decision.
- XFER→IDLE.
- Any state→HOLD on a start.

Top module: `sar_ctrl`

## Requirements
- R1: Bits are decided MSB first. The trial for bit k is the already-decided upper bits with bit k set and the lower bits clear. The bit is kept when `cmp_i`=1 (input at or above the trial). With a comparator model `cmp_i = vin >= trial_o`, the result equals vin, and a full-scale input gives 8'hFF.
- R2: Each bit's trial is held for 8 clocks, so the 8 decisions take 64 clocks.
- R3: While `cs_n` and `wr_n` are both low, `trial_o` is 0 and `intr_n_o` is 1, however long the hold lasts.
- R4: A conversion begins 1 to 8 clocks after the start strobe is released and aligns to the phase counter. Counted from the clock edge after the release is driven, `intr_n_o` falls on edge 69 to 76.
- R5: The finished word is latched at the last decision and `intr_n_o` falls on the next clock. The latch changes at no other time.
- R6: While `cs_n` and `rd_n` are both low, `data_oe_o`=1 and `data_o` shows the latched word, and `intr_n_o` returns high. Otherwise `data_oe_o`=0 and `data_o`=0.
- R7: A start during a conversion restarts the conversion from the MSB. The latch keeps the previous result.
- R8: With `cs_n` low and `wr_n` fed from `intr_n_o`, one forced low pulse on write makes the block convert continuously. Each result equals the input.
- R9: With `cs_n` high, `wr_n` and `rd_n` have no effect.
- R10: After reset, `intr_n_o`=1, `data_oe_o`=0, `data_o`=0 and `trial_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low start strobe |
| rd_n | input | 1 | Active-low read strobe |
| cmp_i | input | 1 | Comparator result, 1 when input >= trial code |
| trial_o | output | 8 | Current trial code for the comparator |
| data_o | output | 8 | Latched result, zero when not enabled |
| data_oe_o | output | 1 | Output enable for the data bus |
| intr_n_o | output | 1 | Active-low conversion-complete interrupt |

## Verification
The hardest situation to reach is free-running operation. There the bench itself must close the loop from `intr_n_o` back to `wr_n` and give the single forced start pulse before it hands control to the feedback path. The bench counts the interrupt falls over a fixed window and reads the result back only after opening the loop again. A restart in the middle of a conversion is set up by changing the modelled input voltage while the hold is active. A read taken during that hold must return the older word.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_ALIGN,
        ST_CONV,
        ST_XFER
    } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= '1;
        end else begin
            pipe_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
        end
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/sar_phase.sv
module sar_phase #(
    parameter int CLKS_PER_BIT = 8,
    localparam int PH_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_o,
    output logic            last_o
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_BIT - 1);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              ph_q <= '0;
        else if (ph_q == PH_LAST) ph_q <= '0;
        else                     ph_q <= ph_q + 1'b1;
    end

    assign phase_o = ph_q;
    assign last_o  = (ph_q == PH_LAST);
endmodule

// File: rtl/sar_bits.sv
module sar_bits #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              load_i,
    input  logic              decide_i,
    input  logic              keep_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] trial_o,
    output logic [DATA_W-1:0] final_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    logic [DATA_W-1:0] trial_q;
    logic [DATA_W-1:0] bit_mask;

    assign bit_mask = ONE << idx_i;
    assign final_o  = keep_i ? trial_q : (trial_q & ~bit_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q <= '0;
        end else if (clr_i) begin
            trial_q <= '0;
        end else if (load_i) begin
            trial_q <= ONE << (DATA_W - 1);
        end else if (decide_i) begin
            if (idx_i != '0) trial_q <= final_o | (bit_mask >> 1);
            else             trial_q <= final_o;
        end
    end

    assign trial_o = trial_q;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int CLKS_PER_BIT = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              cmp_i,
    output logic [DATA_W-1:0] trial_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              intr_n_o
);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int PH_W  = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [IDX_W-1:0] IDX_MSB = IDX_W'(DATA_W - 1);

    logic [2:0]        bus_s;
    logic              cs_s, wr_s, rd_s;
    logic              start_req, rd_act;
    logic [PH_W-1:0]   ph;
    logic              ph_last;
    sar_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              sar_load, sar_decide, last_bit;
    logic [DATA_W-1:0] sar_final;
    logic [DATA_W-1:0] data_q;
    logic              intr_n_q;

    sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, wr_n, rd_n}),
        .sync_o  (bus_s)
    );

    assign {cs_s, wr_s, rd_s} = bus_s;
    assign start_req = !cs_s && !wr_s;
    assign rd_act    = !cs_s && !rd_s;

    sar_phase #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (ph),
        .last_o  (ph_last)
    );

    assign last_bit   = (idx_q == '0);
    assign sar_load   = (state_q == ST_ALIGN) && !start_req && ph_last;
    assign sar_decide = (state_q == ST_CONV)  && !start_req && ph_last;

    sar_bits #(.DATA_W(DATA_W)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (start_req),
        .load_i   (sar_load),
        .decide_i (sar_decide),
        .keep_i   (cmp_i),
        .idx_i    (idx_q),
        .trial_o  (trial_o),
        .final_o  (sar_final)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_req) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_HOLD:  state_d = ST_ALIGN;
                ST_ALIGN: state_d = ph_last ? ST_CONV : ST_ALIGN;
                ST_CONV:  state_d = (ph_last && last_bit) ? ST_XFER : ST_CONV;
                ST_XFER:  state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            data_q   <= '0;
            intr_n_q <= 1'b1;
        end else begin
            if (sar_load)                     idx_q <= IDX_MSB;
            else if (sar_decide && !last_bit) idx_q <= idx_q - 1'b1;

            if (sar_decide && last_bit) data_q <= sar_final;

            if (start_req)                intr_n_q <= 1'b1;
            else if (state_q == ST_XFER)  intr_n_q <= 1'b0;
            else if (rd_act)              intr_n_q <= 1'b1;
        end
    end

    assign intr_n_o  = intr_n_q;
    assign data_oe_o = rd_act;
    assign data_o    = rd_act ? data_q : '0;
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk
    import sar_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PH_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              intr_n_o,
    input logic [DATA_W-1:0] trial_o,
    input logic              start_req,
    input logic              rd_act,
    input sar_state_e        state_q,
    input logic [PH_W-1:0]   ph,
    input logic [DATA_W-1:0] data_q
);
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (trial_o == '0) && intr_n_o); // R3

    AST_CONV_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_CONV) && ($past(state_q) == ST_ALIGN)) |-> (ph == '0)); // R4

    AST_CONV_TRIAL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV) |-> (trial_o != '0)); // R1

    AST_LATCH_THEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_q != $past(data_q)) && !start_req) |=> !intr_n_o); // R5

    AST_FLAG_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_n_o) |-> ($past(state_q) == ST_XFER)); // R5

    AST_ABORT_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_HOLD) && ($past(state_q) == ST_CONV)) |-> $stable(data_q)); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !start_req && (state_q != ST_XFER)) |=> intr_n_o); // R6
endmodule

bind sar_ctrl sar_ctrl_chk #(.DATA_W(DATA_W), .PH_W(PH_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .intr_n_o  (intr_n_o),
    .trial_o   (trial_o),
    .start_req (start_req),
    .rd_act    (rd_act),
    .state_q   (state_q),
    .ph        (ph),
    .data_q    (data_q)
);

// File: tb/sar_ctrl_tb.sv
`timescale 1ns/1ps
module sar_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       wr_drv = 1'b1;
    logic       rd_n = 1'b1;
    logic       free_mode = 1'b0;
    logic [7:0] vin = 8'h00;
    logic       wr_n;
    logic       cmp;
    logic [7:0] trial, data;
    logic       oe, intr_n;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    assign wr_n = free_mode ? intr_n : wr_drv;
    assign cmp  = (vin >= trial);

    sar_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cmp_i(cmp), .trial_o(trial), .data_o(data), .data_oe_o(oe), .intr_n_o(intr_n)
    );

    // each entry: {vin, expected result}
    localparam logic [15:0] VECS [8] = '{
        {8'h00, 8'h00}, {8'hFF, 8'hFF}, {8'h80, 8'h80}, {8'h7F, 8'h7F},
        {8'h01, 8'h01}, {8'h55, 8'h55}, {8'hAA, 8'hAA}, {8'hC3, 8'hC3}
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_pulse(input int hold);
        @(negedge clk);
        cs_n = 1'b0; wr_drv = 1'b0;
        cyc(hold);
        wr_drv = 1'b1;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (intr_n && n < 300);
    endtask

    task automatic read_word(output logic [7:0] w, output logic e);
        rd_n = 1'b0;
        cyc(4);
        w = data; e = oe;
        rd_n = 1'b1;
        cyc(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int n;
        logic [7:0] w;
        logic e;
        cyc(3);
        // R10 reset state
        chk(intr_n == 1'b1 && oe == 1'b0 && data == 8'h00 && trial == 8'h00,
            "R10", {intr_n, oe, data, trial}, 18'h20000);
        rst_n = 1'b1;
        cyc(12);

        // vector table: R1 R4 R5 R6
        foreach (VECS[i]) begin
            vin = VECS[i][15:8];
            start_pulse(3);
            wait_done(n);
            chk(n >= 69 && n <= 76, "R4 start-to-flag clocks", n, 69);
            chk(intr_n == 1'b0, "R5 flag low", intr_n, 0);
            read_word(w, e);
            chk(e == 1'b1, "R6 oe", e, 1);
            chk(w == VECS[i][7:0], "R1 result", w, VECS[i][7:0]);
            chk(intr_n == 1'b1 && oe == 1'b0 && data == 8'h00, "R6 after read",
                {intr_n, oe, data}, 10'h200);
        end

        // R2: trial sequence for 0x55, one bit per 8 clocks
        begin
            logic [7:0] seq [8] = '{8'h80, 8'h40, 8'h60, 8'h50, 8'h58, 8'h54, 8'h56, 8'h55};
            vin = 8'h55;
            start_pulse(3);
            n = 0;
            while (trial != 8'h80 && n < 40) begin cyc(1); n++; end
            cyc(4);
            for (int k = 0; k < 8; k++) begin
                chk(trial == seq[k], "R2 trial per bit", trial, seq[k]);
                if (k < 7) cyc(8);
            end
            wait_done(n);
            read_word(w, e);
            chk(w == 8'h55, "R1 result 55", w, 8'h55);
        end

        // R3: long hold keeps converter reset
        vin = 8'hF0;
        @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
        cyc(200);
        chk(trial == 8'h00 && intr_n == 1'b1, "R3 hold", {trial, intr_n}, 9'h001);
        wr_drv = 1'b1;
        wait_done(n);
        chk(n >= 69 && n <= 76, "R4 after long hold", n, 69);
        read_word(w, e);
        chk(w == 8'hF0, "R3 result after hold", w, 8'hF0);

        // R7: restart mid conversion keeps latch, then new result
        vin = 8'hAA;
        start_pulse(3);
        cyc(40);
        vin = 8'h3C;
        @(negedge clk); wr_drv = 1'b0;
        cyc(4);
        chk(intr_n == 1'b1 && trial == 8'h00, "R7 restart holds", {intr_n, trial}, 9'h001);
        rd_n = 1'b0; cyc(4);
        chk(data == 8'hF0, "R7 latch kept", data, 8'hF0);
        rd_n = 1'b1; cyc(2);
        wr_drv = 1'b1;
        wait_done(n);
        read_word(w, e);
        chk(w == 8'h3C, "R7 new result", w, 8'h3C);

        // R9: strobes ignored with select high
        vin = 8'h11;
        start_pulse(3);
        wait_done(n);
        @(negedge clk); cs_n = 1'b1; wr_drv = 1'b0; rd_n = 1'b0;
        cyc(30);
        chk(intr_n == 1'b0 && oe == 1'b0 && data == 8'h00 && trial == 8'h11,
            "R9 ignored", {intr_n, oe, data, trial}, 18'h00011);
        wr_drv = 1'b1; rd_n = 1'b1;
        cyc(4);
        cs_n = 1'b0;
        read_word(w, e);
        chk(w == 8'h11, "R9 latch intact", w, 8'h11);

        // R8: free-running with interrupt fed back to write
        vin = 8'h9D;
        @(negedge clk); wr_drv = 1'b0;
        cyc(3);
        free_mode = 1'b1;
        begin
            int falls = 0;
            logic prev = 1'b1;
            for (int c = 0; c < 500; c++) begin
                @(negedge clk);
                if (prev && !intr_n) falls++;
                prev = intr_n;
            end
            chk(falls >= 5, "R8 conversions in 500 clocks", falls, 5);
        end
        wr_drv = 1'b1;
        free_mode = 1'b0;
        cyc(100);
        read_word(w, e);
        chk(w == 8'h9D, "R8 free-run result", w, 8'h9D);

        summary();
    end
endmodule